// File: doc/BRIEF.md
# Bit-Slice ALU With Operand Enables

This block is a combinational arithmetic-logic unit made of identical one-bit slices. Each slice holds one column of the two operands, and all slices share the same controls. A ripple carry runs from the least significant slice to the most significant one. In each slice, the A bit and the B bit first pass through an enable gate, and the gated A bit can then be inverted. After that conditioning, a two-bit function code selects one of four operations: AND, OR, the complement of B, or a full-adder sum.

The carry into the lowest slice is an input. With it, the block can increment (B disabled and carry in set), add with carry, or subtract (A inverted and carry in set, which gives B minus A). The carry out of the top slice is exported. The carry out of the slice just below the top is also exported, and a signed-overflow bit is formed from these two carries. A surrounding datapath drives the operands and controls and takes the outputs in the same cycle.

Top module: `bitslice_alu`

## Requirements
- R1: With `fn_sel` = 2'b00, `result` equals the bitwise AND of the conditioned A and the conditioned B. Conditioned A is (`en_a` ? `op_a` : 0), XORed with all ones when `inv_a` = 1. Conditioned B is (`en_b` ? `op_b` : 0).
- R2: With `fn_sel` = 2'b01, `result` equals the bitwise OR of conditioned A and conditioned B.
- R3: With `fn_sel` = 2'b10, `result` equals the complement of conditioned B, and conditioned A has no effect.
- R4: With `fn_sel` = 2'b11, {`carry_out`, `result`} equals conditioned A + conditioned B + `carry_in`.
- R5: A disabled operand is zero. Inversion acts after the enable gate, so `en_a` = 0 with `inv_a` = 1 gives an all-ones A.
- R6: In the three logical modes (`fn_sel` other than 2'b11), `carry_out` and `carry_hi_m1` are both 0.
- R7: In add mode, `carry_hi_m1` is the carry out of the slice at bit WIDTH-2 (bit 6 at the default width). That is bit WIDTH-1 of the sum of the low WIDTH-1 bits of both conditioned operands plus `carry_in`.
- R8: `overflow` equals `carry_out` XOR `carry_hi_m1`. In add mode, this is 1 exactly when the signed sum does not fit in WIDTH bits.
- R9: In add mode with `en_b` = 0 and `carry_in` = 1, `result` is `op_a` + 1, and `op_b` is ignored.
- R10: In the logical modes, `carry_in` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| fn_sel | input | 2 | Function code: 00 AND, 01 OR, 10 NOT B, 11 add |
| en_a | input | 1 | Passes A when 1, forces it to zero when 0 |
| en_b | input | 1 | Passes B when 1, forces it to zero when 0 |
| inv_a | input | 1 | Inverts A after the enable gate |
| carry_in | input | 1 | Carry into the least significant slice |
| result | output | WIDTH | Function result |
| carry_out | output | 1 | Carry out of the most significant slice |
| carry_hi_m1 | output | 1 | Carry out of the slice at bit WIDTH-2 |
| overflow | output | 1 | Signed overflow: XOR of the two exported carries |

## Verification
The logical modes use operands with complementary and overlapping bit patterns, so a swapped function code or a missing inversion gives a different word. In add mode, the operands are chosen to separate the two exported carries: 0x40+0x40 sets only the bit-6 carry, 0x80+0x80 sets only the final carry, and 0xC0+0xC0 sets both. This shows whether the overflow bit uses the right pair of carries. The enable tests combine a disabled A with inversion on and off, which exposes the order of gating and inversion. The increment and logical-mode tests hold the operands fixed and change `op_b` or `carry_in` to show that these inputs are ignored.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
   typedef enum logic [1:0] {
      FN_AND  = 2'b00,
      FN_OR   = 2'b01,
      FN_NOTB = 2'b10,
      FN_ADD  = 2'b11
   } fn_e;
endpackage

// File: rtl/bsalu_operand.sv
// Operand conditioning for one column: enable gate first, then optional inversion.
module bsalu_operand (
   input  logic bit_in,
   input  logic enable,
   input  logic invert,
   output logic bit_out
);
   logic gated;

   always_comb begin
      gated   = bit_in & enable;
      bit_out = gated ^ invert;
   end

   always_comb begin
      if (!$isunknown({enable, invert, bit_out}) && !enable) begin
         AST_DISABLED_FOLLOWS_INV: assert (bit_out == invert)
            else $error("disabled operand not equal to invert control"); // R5
      end
   end
endmodule

// File: rtl/bsalu_half_add.sv
module bsalu_half_add (
   input  logic x,
   input  logic y,
   output logic s,
   output logic c
);
   always_comb begin
      s = x ^ y;
      c = x & y;
   end
endmodule

// File: rtl/bsalu_fn_unit.sv
// Four-function column logic; the adder form is picked by a parameter.
module bsalu_fn_unit
   import bsalu_pkg::*;
#(
   parameter bit SPLIT_ADDER = 1'b1
) (
   input  logic a,
   input  logic b,
   input  logic cin,
   input  fn_e  fn,
   output logic res,
   output logic cout
);
   logic sum_bit;
   logic sum_carry;

   generate
      if (SPLIT_ADDER) begin : g_two_half
         logic s1, c1, c2;
         bsalu_half_add u_ha0 (.x(a),  .y(b),   .s(s1),      .c(c1));
         bsalu_half_add u_ha1 (.x(s1), .y(cin), .s(sum_bit), .c(c2));
         assign sum_carry = c1 | c2;
      end else begin : g_flat
         assign sum_bit   = a ^ b ^ cin;
         assign sum_carry = (a & b) | (a & cin) | (b & cin);
      end
   endgenerate

   always_comb begin
      res  = 1'b0;
      cout = 1'b0;
      unique case (fn)
         FN_AND:  res = a & b;
         FN_OR:   res = a | b;
         FN_NOTB: res = ~b;
         FN_ADD: begin
            res  = sum_bit;
            cout = sum_carry;
         end
         default: res = 1'b0;
      endcase
   end
endmodule

// File: rtl/bsalu_slice.sv
// One column of the ALU: operand conditioning followed by the function unit.
module bsalu_slice
   import bsalu_pkg::*;
#(
   parameter bit SPLIT_ADDER = 1'b1
) (
   input  logic a,
   input  logic b,
   input  logic en_a,
   input  logic en_b,
   input  logic inv_a,
   input  fn_e  fn,
   input  logic cin,
   output logic res,
   output logic cout
);
   logic a_c, b_c;

   bsalu_operand u_opa (.bit_in(a), .enable(en_a), .invert(inv_a), .bit_out(a_c));
   bsalu_operand u_opb (.bit_in(b), .enable(en_b), .invert(1'b0),  .bit_out(b_c));

   bsalu_fn_unit #(.SPLIT_ADDER(SPLIT_ADDER)) u_fn (
      .a(a_c), .b(b_c), .cin(cin), .fn(fn), .res(res), .cout(cout)
   );

   always_comb begin
      if (!$isunknown({fn, cout}) && fn != FN_ADD) begin
         AST_LOGIC_NO_CARRY: assert (cout == 1'b0)
            else $error("carry out set in a logical mode"); // R6
      end
      if (!$isunknown({fn, res, b_c}) && fn == FN_NOTB) begin
         AST_NOTB_DIFFERS: assert (res != b_c)
            else $error("NOT B mode returned B"); // R3
      end
   end
endmodule

// File: rtl/bitslice_alu.sv
// N-bit ALU built from a ripple chain of one-bit slices.
module bitslice_alu
   import bsalu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit SPLIT_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [1:0]       fn_sel,
   input  logic             en_a,
   input  logic             en_b,
   input  logic             inv_a,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             carry_hi_m1,
   output logic             overflow
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bitslice_alu needs WIDTH of at least 2");
      end
   endgenerate

   fn_e              fn;
   logic [WIDTH:0]   chain;

   assign fn       = fn_e'(fn_sel);
   assign chain[0] = carry_in;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_col
         bsalu_slice #(.SPLIT_ADDER(SPLIT_ADDER)) u_slice (
            .a(op_a[i]), .b(op_b[i]), .en_a(en_a), .en_b(en_b), .inv_a(inv_a),
            .fn(fn), .cin(chain[i]), .res(result[i]), .cout(chain[i+1])
         );
      end
   endgenerate

   assign carry_out   = chain[WIDTH];
   assign carry_hi_m1 = chain[MSB];
   assign overflow    = carry_out ^ carry_hi_m1;

   logic [WIDTH-1:0] a_chk, b_chk;
   logic [WIDTH:0]   sum_chk;

   always_comb begin
      a_chk   = (en_a ? op_a : '0) ^ {WIDTH{inv_a}};
      b_chk   = en_b ? op_b : '0;
      sum_chk = {1'b0, a_chk} + {1'b0, b_chk} + {{WIDTH{1'b0}}, carry_in};
      if (!$isunknown({op_a, op_b, fn_sel, en_a, en_b, inv_a, carry_in, result, carry_out})
          && fn == FN_ADD) begin
         AST_ADD_SUM: assert ({carry_out, result} == sum_chk)
            else $error("add mode sum mismatch"); // R4
         AST_SIGNED_OVERFLOW: assert (overflow ==
               ((a_chk[MSB] == b_chk[MSB]) && (result[MSB] != a_chk[MSB])))
            else $error("overflow does not match signed range"); // R8
      end
   end
endmodule

// File: tb/bitslice_alu_test.sv
module bitslice_alu_test;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [W-1:0] op_a, op_b, result;
   logic [1:0]   fn_sel;
   logic         en_a, en_b, inv_a, carry_in;
   logic         carry_out, carry_hi_m1, overflow;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   bitslice_alu #(.WIDTH(W)) uut (
      .op_a(op_a), .op_b(op_b), .fn_sel(fn_sel), .en_a(en_a), .en_b(en_b),
      .inv_a(inv_a), .carry_in(carry_in), .result(result),
      .carry_out(carry_out), .carry_hi_m1(carry_hi_m1), .overflow(overflow)
   );

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] f,
                        input logic ea, input logic eb, input logic ia, input logic ci);
      @(negedge clk);
      op_a = a; op_b = b; fn_sel = f; en_a = ea; en_b = eb; inv_a = ia; carry_in = ci;
      #3;
   endtask

   // Expected outputs built from the requirement text.
   task automatic check_all(input string req);
      logic [W-1:0] ac, bc, er;
      logic [W:0]   full;
      logic [W-1:0] low;
      logic         ec, e6, eo;
      ac   = (en_a ? op_a : '0) ^ {W{inv_a}};
      bc   = en_b ? op_b : '0;
      full = {1'b0, ac} + {1'b0, bc} + {{W{1'b0}}, carry_in};
      low  = {1'b0, ac[W-2:0]} + {1'b0, bc[W-2:0]} + {{(W-1){1'b0}}, carry_in};
      ec = 1'b0; e6 = 1'b0;
      case (fn_sel)
         2'b00: er = ac & bc;
         2'b01: er = ac | bc;
         2'b10: er = ~bc;
         default: begin er = full[W-1:0]; ec = full[W]; e6 = low[W-1]; end
      endcase
      eo = ec ^ e6;
      checks++;
      if (result !== er || carry_out !== ec || carry_hi_m1 !== e6 || overflow !== eo) begin
         errors++;
         $display("FAIL %s res=%h/%h cout=%b/%b c6=%b/%b ovf=%b/%b (actual/expected)",
                  req, result, er, carry_out, ec, carry_hi_m1, e6, overflow, eo);
      end
   endtask

   task automatic check_val(input string req, input logic [W-1:0] exp_r);
      checks++;
      if (result !== exp_r) begin
         errors++;
         $display("FAIL %s res=%h expected %h", req, result, exp_r);
      end
   endtask

   task automatic t_reset;
      drive('0, '0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
      check_all("R1 reset");
      check_val("R1 reset", 8'h00);
   endtask

   task automatic t_and;
      drive(8'hF0, 8'hCC, 2'b00, 1, 1, 0, 0); check_all("R1"); check_val("R1", 8'hC0);
      drive(8'hF0, 8'hCC, 2'b00, 1, 1, 1, 0); check_val("R1", 8'h0C);
   endtask

   task automatic t_or;
      drive(8'hA0, 8'h05, 2'b01, 1, 1, 0, 0); check_val("R2", 8'hA5); check_all("R2");
      drive(8'hA0, 8'h05, 2'b01, 1, 1, 1, 0); check_val("R2", 8'h5F);
   endtask

   task automatic t_notb;
      drive(8'h3C, 8'h5A, 2'b10, 1, 1, 0, 0); check_val("R3", 8'hA5);
      drive(8'h00, 8'h5A, 2'b10, 0, 1, 1, 0); check_val("R3", 8'hA5);
      drive(8'h77, 8'h5A, 2'b10, 1, 0, 0, 0); check_val("R3", 8'hFF); check_all("R3");
   endtask

   task automatic t_add;
      drive(8'h12, 8'h34, 2'b11, 1, 1, 0, 0); check_val("R4", 8'h46); check_all("R4");
      drive(8'hFF, 8'h01, 2'b11, 1, 1, 0, 0); check_all("R4");
      drive(8'h12, 8'h34, 2'b11, 1, 1, 0, 1); check_val("R4", 8'h47);
      drive(8'h05, 8'h09, 2'b11, 1, 1, 1, 1); check_val("R4", 8'h04); check_all("R4");
   endtask

   task automatic t_enables;
      drive(8'h99, 8'h3C, 2'b00, 0, 1, 1, 0); check_val("R5", 8'h3C);
      drive(8'h99, 8'h3C, 2'b01, 0, 1, 0, 0); check_val("R5", 8'h3C);
      drive(8'h99, 8'h3C, 2'b01, 0, 0, 1, 0); check_val("R5", 8'hFF);
      drive(8'h99, 8'h3C, 2'b01, 1, 0, 0, 0); check_val("R5", 8'h99);
   endtask

   task automatic t_logic_carry;
      for (int f = 0; f < 3; f++) begin
         logic [W-1:0] r0;
         drive(8'hFF, 8'hFF, f[1:0], 1, 1, 0, 0); r0 = result; check_all("R6");
         drive(8'hFF, 8'hFF, f[1:0], 1, 1, 0, 1); check_val("R10", r0); check_all("R6");
      end
   endtask

   task automatic t_carries;
      drive(8'h40, 8'h40, 2'b11, 1, 1, 0, 0); check_all("R7");
      checks++; if (carry_hi_m1 !== 1'b1 || carry_out !== 1'b0 || overflow !== 1'b1) begin
         errors++; $display("FAIL R8 c6=%b cout=%b ovf=%b expected 1 0 1", carry_hi_m1, carry_out, overflow); end
      drive(8'h80, 8'h80, 2'b11, 1, 1, 0, 0); check_all("R7");
      checks++; if (carry_hi_m1 !== 1'b0 || carry_out !== 1'b1 || overflow !== 1'b1) begin
         errors++; $display("FAIL R8 c6=%b cout=%b ovf=%b expected 0 1 1", carry_hi_m1, carry_out, overflow); end
      drive(8'hC0, 8'hC0, 2'b11, 1, 1, 0, 0); check_all("R8");
      checks++; if (carry_hi_m1 !== 1'b1 || carry_out !== 1'b1 || overflow !== 1'b0) begin
         errors++; $display("FAIL R8 c6=%b cout=%b ovf=%b expected 1 1 0", carry_hi_m1, carry_out, overflow); end
   endtask

   task automatic t_increment;
      drive(8'h41, 8'hA5, 2'b11, 1, 0, 0, 1); check_val("R9", 8'h42);
      drive(8'h41, 8'h5A, 2'b11, 1, 0, 0, 1); check_val("R9", 8'h42);
      drive(8'h7F, 8'hA5, 2'b11, 1, 0, 0, 1); check_val("R9", 8'h80); check_all("R9");
      drive(8'hFF, 8'h13, 2'b11, 1, 0, 0, 1); check_val("R9", 8'h00); check_all("R9");
   endtask

   initial begin
      op_a = '0; op_b = '0; fn_sel = '0; en_a = 0; en_b = 0; inv_a = 0; carry_in = 0;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_and();
      t_or();
      t_notb();
      t_add();
      t_enables();
      t_logic_carry();
      t_carries();
      t_increment();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired before tests completed");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule